// File: doc/BRIEF.md
# Programmable Post-Configuration Startup Sequencer

This block runs the short startup phase that follows the loading of configuration data. Once the configuration-complete input rises, it walks a phase counter from 0 to 7. On the way it releases five sticky control outputs: the DONE drive, the output enable, the release of the global set/reset, the release of the global write enable, and the clock-manager lock acknowledge. Each of these outputs is placed on the schedule by its own 3-bit code, which is captured when the sequence starts.

The counter is stepped by single-cycle tick strobes that come from three clock sources: the configuration clock, a user clock and a test clock. The step out of phase 0 always uses the configuration tick. Later steps use the tick that was selected at start. Three of the events can be told to wait for a sensed DONE level. The clock-manager event can stall the counter until lock is reported. The sensed DONE can either be the raw pin or the pin as it was captured on the previous startup tick.

All state runs in the `clk` domain, and every tick input is a one-`clk` strobe. A synchronous active-low reset brings the block back to idle at phase 0.

Top module: `startup_seq`

## Requirements
- R1: A rising edge of `cfg_complete` starts the sequence at phase 0. Each qualifying tick then advances `phase` by exactly one, up to 7, where it stays. `finished` is high only while running at phase 7.
- R2: The step from phase 0 to phase 1 uses `cfg_tick`. Every later step uses the tick picked by `clk_sel`: 0 selects `cfg_tick`, 1 selects `usr_tick`, 2 selects `tst_tick`, and 3 selects `cfg_tick`. Ticks from sources that are not selected move nothing.
- R3: `done_drive` rises once `phase` reaches `done_code` when the code is 1 to 6. Codes 0 and 7 behave as 6.
- R4: For `oe_code`, `gsr_code` and `gwe_code`, a value from 1 to 6 releases the matching output (`out_en`, `gsr_rel`, `gwe_rel`) once `phase` reaches that value.
- R5: A code of 7 on `oe_code`, `gsr_code` or `gwe_code` keeps the matching output low for the whole sequence.
- R6: A code of 0 on `oe_code`, `gsr_code` or `gwe_code` means wait for DONE. The default positions are phase 4 for the output enable, 5 for set/reset and 6 for write enable. The output is released at the first phase at or after its default position where the sensed DONE is high. Until that happens the counter stalls at that phase.
- R7: When `done_pipe_en` is high at start, the sensed DONE is the value of `done_pin` captured on the previous startup tick. Otherwise it is `done_pin` itself.
- R8: A `lock_code` from 0 to 6 stalls the counter at that phase while `lock_in` is low. `lock_ok` rises once `phase` is at or past the code and `lock_in` is high. Code 7 never stalls, and it raises `lock_ok` as soon as the sequence is running.
- R9: Every released output stays high until `rst_n` is sampled low. That reset clears all outputs and returns `phase` to 0.
- R10: The clock select, the pipe enable and all event codes are captured on the starting edge. Later changes to them, and later rising edges of `cfg_complete`, have no effect until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all state updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_complete | input | 1 | Configuration data loaded; its rising edge starts the sequence |
| clk_sel | input | 2 | Step source after phase 1 (0 config, 1 user, 2 test, 3 config) |
| done_pipe_en | input | 1 | Use the previous-tick copy of the DONE pin |
| done_code | input | 3 | Phase for the DONE drive |
| oe_code | input | 3 | Output-enable schedule (1-6 phase, 0 wait DONE, 7 keep) |
| gsr_code | input | 3 | Set/reset release schedule (same encoding) |
| gwe_code | input | 3 | Write-enable release schedule (same encoding) |
| lock_code | input | 3 | Lock wait phase (0-6) or 7 for no wait |
| cfg_tick | input | 1 | Configuration clock step strobe |
| usr_tick | input | 1 | User clock step strobe |
| tst_tick | input | 1 | Test clock step strobe |
| done_pin | input | 1 | Sensed external DONE level |
| lock_in | input | 1 | Clock-manager lock indication |
| phase | output | 3 | Current startup phase |
| done_drive | output | 1 | DONE drive event |
| out_en | output | 1 | Output enable event |
| gsr_rel | output | 1 | Global set/reset released |
| gwe_rel | output | 1 | Global write enable released |
| lock_ok | output | 1 | Clock-manager lock event satisfied |
| finished | output | 1 | Sequence has reached phase 7 |

## Verification
The bench builds the block with its default wait positions of 4, 5 and 6. Each DONE-wait event therefore has a distinct phase where it can stall, which lets a single wait point be told apart from its neighbours. Because the phase width is fixed at three bits, every schedule code and every phase value can be reached. The table walks each selected clock source through all eight phases. The directed cases look at the places where the counter stops: a DONE wait with and without the pipe, a lock wait, and the refusal of off-source ticks.

// File: rtl/startup_seq_pkg.sv
// Package: shared constants and types for the startup sequencer.
// Assumes the phase and code widths stay at three bits; the encodings rely on it.
package startup_seq_pkg;

    localparam int PH_W = 3;
    localparam int CODE_W = 3;
    localparam logic [PH_W-1:0] PH_LAST = 3'd7;
    localparam logic [CODE_W-1:0] CODE_WAIT_DONE = 3'd0;
    localparam logic [CODE_W-1:0] CODE_KEEP = 3'd7;
    localparam logic [CODE_W-1:0] CODE_NO_WAIT = 3'd7;
    localparam int N_GATED = 3;

    typedef enum logic [1:0] {
        SRC_CFG  = 2'd0,
        SRC_USER = 2'd1,
        SRC_TEST = 2'd2,
        SRC_ALT  = 2'd3
    } step_src_e;

    typedef struct packed {
        step_src_e         src;
        logic              pipe;
        logic [CODE_W-1:0] done_c;
        logic [CODE_W-1:0] oe_c;
        logic [CODE_W-1:0] gsr_c;
        logic [CODE_W-1:0] gwe_c;
        logic [CODE_W-1:0] lock_c;
    } seq_cfg_t;

endpackage

// File: rtl/su_cfg_capture.sv
// Module: detects the starting edge and freezes the schedule settings.
// Assumes start_i is synchronous to clk; only the first edge after reset counts.
module su_cfg_capture
    import startup_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  seq_cfg_t cfg_i,
    output seq_cfg_t cfg_q,
    output logic     running_q,
    output logic     launch
);

    logic start_prev;

    assign launch = start_i && !start_prev && !running_q;

    // Purpose: remember the previous start level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) start_prev <= 1'b0;
        else        start_prev <= start_i;
    end

    // Purpose: latch the settings and enter the running state on launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            cfg_q     <= '0;
        end else if (launch) begin
            running_q <= 1'b1;
            cfg_q     <= cfg_i;
        end
    end

    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        running_q |=> $stable(cfg_q));

    p_run_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        running_q |=> running_q);

endmodule

// File: rtl/su_step_src.sv
// Module: picks the tick that steps the counter and forms the sensed DONE.
// Assumes the tick inputs are one-clk strobes already in the clk domain.
module su_step_src
    import startup_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            running,
    input  logic [PH_W-1:0] phase,
    input  step_src_e       src,
    input  logic            pipe,
    input  logic            cfg_tick,
    input  logic            usr_tick,
    input  logic            tst_tick,
    input  logic            done_pin,
    output logic            tick,
    output logic            done_eff
);

    logic sel_tick;
    logic done_q;

    // Purpose: map the captured source code onto one tick strobe.
    always_comb begin
        unique case (src)
            SRC_USER: sel_tick = usr_tick;
            SRC_TEST: sel_tick = tst_tick;
            default:  sel_tick = cfg_tick;
        endcase
    end

    assign tick     = running && ((phase == '0) ? cfg_tick : sel_tick);
    assign done_eff = pipe ? done_q : done_pin;

    // Purpose: capture the DONE pin once per startup tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    done_q <= 1'b0;
        else if (tick) done_q <= done_pin;
    end

    p_first_step_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == '0 && !cfg_tick) |-> !tick);

endmodule

// File: rtl/su_event_gate.sv
// Module: one schedulable event with phase, wait-for-DONE and keep modes.
// Assumes phase never moves backwards while running and DFLT_POS lies in 1..6.
module su_event_gate
    import startup_seq_pkg::*;
#(
    parameter int DFLT_POS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              running,
    input  logic [PH_W-1:0]   phase,
    input  logic [CODE_W-1:0] code,
    input  logic              done_eff,
    output logic              rel_q,
    output logic              hold
);

    localparam logic [PH_W-1:0] DPOS = PH_W'(DFLT_POS);

    logic            is_keep;
    logic            is_wait;
    logic [PH_W-1:0] pos;
    logic            set_ev;

    assign is_keep = (code == CODE_KEEP);
    assign is_wait = (code == CODE_WAIT_DONE);
    assign pos     = is_wait ? DPOS : code;
    assign set_ev  = running && !is_keep && (phase >= pos) && (!is_wait || done_eff);
    assign hold    = running && is_wait && !rel_q && (phase >= pos) && !done_eff;

    // Purpose: sticky release flag for this event.
    always_ff @(posedge clk) begin
        if (!rst_n)      rel_q <= 1'b0;
        else if (set_ev) rel_q <= 1'b1;
    end

    p_keep_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        is_keep |-> !rel_q);

    p_wait_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rel_q) && is_wait) |-> $past(done_eff));

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rel_q |=> rel_q);

endmodule

// File: rtl/startup_seq.sv
// Module: top of the startup sequencer; phase counter, stall logic and events.
// Assumes all tick strobes and level inputs are synchronous to clk.
module startup_seq
    import startup_seq_pkg::*;
#(
    parameter int OE_DFLT   = 4,
    parameter int GSR_DFLT  = 5,
    parameter int GWE_DFLT  = 6,
    parameter int DONE_FALL = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_complete,
    input  logic [1:0]  clk_sel,
    input  logic        done_pipe_en,
    input  logic [2:0]  done_code,
    input  logic [2:0]  oe_code,
    input  logic [2:0]  gsr_code,
    input  logic [2:0]  gwe_code,
    input  logic [2:0]  lock_code,
    input  logic        cfg_tick,
    input  logic        usr_tick,
    input  logic        tst_tick,
    input  logic        done_pin,
    input  logic        lock_in,
    output logic [2:0]  phase,
    output logic        done_drive,
    output logic        out_en,
    output logic        gsr_rel,
    output logic        gwe_rel,
    output logic        lock_ok,
    output logic        finished
);

    localparam int DFLT [N_GATED] = '{OE_DFLT, GSR_DFLT, GWE_DFLT};
    localparam logic [PH_W-1:0] DONE_FB = PH_W'(DONE_FALL);

    seq_cfg_t          cfg_in;
    seq_cfg_t          cfg_q;
    logic              running;
    logic              launch;
    logic              tick;
    logic              done_eff;
    logic [PH_W-1:0]   cnt_q;
    logic [CODE_W-1:0] gate_code [N_GATED];
    logic [N_GATED-1:0] gate_rel;
    logic [N_GATED-1:0] gate_hold;
    logic              lock_hold;
    logic              stall;
    logic              step;
    logic [PH_W-1:0]   done_pos;
    logic              done_q;
    logic              lock_q;

    assign cfg_in = '{src: step_src_e'(clk_sel), pipe: done_pipe_en, done_c: done_code,
                      oe_c: oe_code, gsr_c: gsr_code, gwe_c: gwe_code, lock_c: lock_code};

    su_cfg_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (cfg_complete),
        .cfg_i     (cfg_in),
        .cfg_q     (cfg_q),
        .running_q (running),
        .launch    (launch)
    );

    su_step_src u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .running  (running),
        .phase    (cnt_q),
        .src      (cfg_q.src),
        .pipe     (cfg_q.pipe),
        .cfg_tick (cfg_tick),
        .usr_tick (usr_tick),
        .tst_tick (tst_tick),
        .done_pin (done_pin),
        .tick     (tick),
        .done_eff (done_eff)
    );

    assign gate_code[0] = cfg_q.oe_c;
    assign gate_code[1] = cfg_q.gsr_c;
    assign gate_code[2] = cfg_q.gwe_c;

    genvar g;
    generate
        for (g = 0; g < N_GATED; g++) begin : g_evt
            su_event_gate #(.DFLT_POS(DFLT[g])) u_gate (
                .clk      (clk),
                .rst_n    (rst_n),
                .running  (running),
                .phase    (cnt_q),
                .code     (gate_code[g]),
                .done_eff (done_eff),
                .rel_q    (gate_rel[g]),
                .hold     (gate_hold[g])
            );
        end
    endgenerate

    assign lock_hold = running && (cfg_q.lock_c != CODE_NO_WAIT)
                       && (cnt_q == cfg_q.lock_c) && !lock_in;
    assign stall     = (|gate_hold) || lock_hold;
    assign step      = tick && !stall && (cnt_q != PH_LAST);
    assign done_pos  = (cfg_q.done_c == '0 || cfg_q.done_c == CODE_KEEP) ? DONE_FB : cfg_q.done_c;

    // Purpose: phase counter, cleared on launch and advanced on each qualified step.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (launch) cnt_q <= '0;
        else if (step)   cnt_q <= cnt_q + 1'b1;
    end

    // Purpose: sticky DONE drive and lock acknowledge events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            lock_q <= 1'b0;
        end else begin
            if (running && cnt_q >= done_pos) done_q <= 1'b1;
            if (running && (cfg_q.lock_c == CODE_NO_WAIT || (cnt_q >= cfg_q.lock_c && lock_in)))
                lock_q <= 1'b1;
        end
    end

    assign phase      = cnt_q;
    assign done_drive = done_q;
    assign out_en     = gate_rel[0];
    assign gsr_rel    = gate_rel[1];
    assign gwe_rel    = gate_rel[2];
    assign lock_ok    = lock_q;
    assign finished   = running && (cnt_q == PH_LAST);

    p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

    p_no_tick_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !tick) |=> $stable(cnt_q));

    p_lock_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cfg_q.lock_c != CODE_NO_WAIT && cnt_q == cfg_q.lock_c && !lock_in)
        |=> $stable(cnt_q));

    p_done_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> done_q);

endmodule

// File: tb/startup_seq_bench.sv
module startup_seq_bench;

    typedef struct packed {
        logic [1:0] sel;
        logic       pipe;
        logic [2:0] dc, oc, gc, wc, lc;
        logic [3:0] ed, eo, eg, ew, el;
    } row_t;

    // expected first phase of each event; 8 means never
    localparam row_t TBL [5] = '{
        '{2'd0, 1'b0, 3'd4, 3'd3, 3'd5, 3'd6, 3'd7, 4'd4, 4'd3, 4'd5, 4'd6, 4'd0},
        '{2'd1, 1'b0, 3'd1, 3'd0, 3'd7, 3'd2, 3'd3, 4'd1, 4'd4, 4'd8, 4'd2, 4'd3},
        '{2'd2, 1'b1, 3'd6, 3'd6, 3'd0, 3'd0, 3'd0, 4'd6, 4'd6, 4'd5, 4'd6, 4'd0},
        '{2'd3, 1'b0, 3'd0, 3'd1, 3'd1, 3'd7, 3'd6, 4'd6, 4'd1, 4'd1, 4'd8, 4'd6},
        '{2'd1, 1'b0, 3'd7, 3'd7, 3'd2, 3'd3, 3'd1, 4'd6, 4'd8, 4'd2, 4'd3, 4'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_complete = 1'b0;
    logic [1:0] clk_sel = '0;
    logic done_pipe_en = 1'b0;
    logic [2:0] done_code = 3'd1, oe_code = 3'd1, gsr_code = 3'd1, gwe_code = 3'd1, lock_code = 3'd7;
    logic cfg_tick = 1'b0, usr_tick = 1'b0, tst_tick = 1'b0;
    logic done_pin = 1'b1, lock_in = 1'b1;
    logic [2:0] phase;
    logic done_drive, out_en, gsr_rel, gwe_rel, lock_ok, finished;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    startup_seq u_startup_seq (
        .clk(clk), .rst_n(rst_n), .cfg_complete(cfg_complete), .clk_sel(clk_sel),
        .done_pipe_en(done_pipe_en), .done_code(done_code), .oe_code(oe_code),
        .gsr_code(gsr_code), .gwe_code(gwe_code), .lock_code(lock_code),
        .cfg_tick(cfg_tick), .usr_tick(usr_tick), .tst_tick(tst_tick),
        .done_pin(done_pin), .lock_in(lock_in), .phase(phase), .done_drive(done_drive),
        .out_en(out_en), .gsr_rel(gsr_rel), .gwe_rel(gwe_rel), .lock_ok(lock_ok),
        .finished(finished)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cfg_complete = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic launch_seq();
        @(negedge clk);
        cfg_complete = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // which: 0 config, 1 user, 2 test
    task automatic pulse(input int which);
        @(negedge clk);
        cfg_tick = (which == 0);
        usr_tick = (which == 1);
        tst_tick = (which == 2);
        @(negedge clk);
        cfg_tick = 1'b0;
        usr_tick = 1'b0;
        tst_tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic set_codes(input logic [1:0] s, input logic p, input logic [2:0] d, o, gs, gw, lk);
        clk_sel = s; done_pipe_en = p; done_code = d; oe_code = o;
        gsr_code = gs; gwe_code = gw; lock_code = lk;
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R9: reset state
        chk("R9 reset phase", int'(phase), 0);
        chk("R9 reset events", int'({done_drive, out_en, gsr_rel, gwe_rel, lock_ok}), 0);
        chk("R1 reset finished", int'(finished), 0);

        // table of schedules walked through all phases (R1 R2 R3 R4 R5 R6 R8)
        for (int r = 0; r < 5; r++) begin
            do_reset();
            done_pin = 1'b1;
            lock_in = 1'b1;
            set_codes(TBL[r].sel, TBL[r].pipe, TBL[r].dc, TBL[r].oc, TBL[r].gc, TBL[r].wc, TBL[r].lc);
            launch_seq();
            for (int p = 0; p < 8; p++) begin
                if (p > 0) pulse((p == 1 || TBL[r].sel == 2'd0 || TBL[r].sel == 2'd3) ? 0 : int'(TBL[r].sel));
                chk("R1 phase", int'(phase), p);
                chk("R1 finished", int'(finished), int'(p == 7));
                chk("R3 done_drive", int'(done_drive), int'(p >= int'(TBL[r].ed)));
                chk("R4 out_en", int'(out_en), int'(p >= int'(TBL[r].eo)));
                chk("R5 gsr_rel", int'(gsr_rel), int'(p >= int'(TBL[r].eg)));
                chk("R6 gwe_rel", int'(gwe_rel), int'(p >= int'(TBL[r].ew)));
                chk("R8 lock_ok", int'(lock_ok), int'(p >= int'(TBL[r].el)));
            end
        end

        // R2: off-source ticks are refused
        do_reset();
        set_codes(2'd1, 1'b0, 3'd1, 3'd1, 3'd1, 3'd1, 3'd7);
        launch_seq();
        pulse(1);
        chk("R2 user tick at phase 0", int'(phase), 0);
        pulse(0);
        chk("R2 config tick into phase 1", int'(phase), 1);
        pulse(0);
        chk("R2 config tick after phase 1", int'(phase), 1);
        pulse(2);
        chk("R2 test tick with user selected", int'(phase), 1);
        pulse(1);
        chk("R2 user tick into phase 2", int'(phase), 2);

        // R6: DONE wait without pipe
        do_reset();
        done_pin = 1'b0;
        set_codes(2'd0, 1'b0, 3'd1, 3'd0, 3'd1, 3'd1, 3'd7);
        launch_seq();
        for (int k = 0; k < 4; k++) pulse(0);
        chk("R6 reached wait phase", int'(phase), 4);
        pulse(0);
        chk("R6 stalled without DONE", int'(phase), 4);
        chk("R6 out_en held", int'(out_en), 0);
        done_pin = 1'b1;
        pulse(0);
        chk("R6 advance after DONE", int'(phase), 5);
        chk("R6 out_en released", int'(out_en), 1);

        // R7: DONE wait with pipe needs one extra tick
        do_reset();
        done_pin = 1'b0;
        set_codes(2'd0, 1'b1, 3'd1, 3'd0, 3'd1, 3'd1, 3'd7);
        launch_seq();
        for (int k = 0; k < 5; k++) pulse(0);
        chk("R7 stalled at wait phase", int'(phase), 4);
        done_pin = 1'b1;
        pulse(0);
        chk("R7 piped DONE not yet seen", int'(phase), 4);
        pulse(0);
        chk("R7 piped DONE seen", int'(phase), 5);
        chk("R7 out_en released", int'(out_en), 1);

        // R8: lock wait at phase 2
        do_reset();
        done_pin = 1'b1;
        lock_in = 1'b0;
        set_codes(2'd0, 1'b0, 3'd1, 3'd1, 3'd1, 3'd1, 3'd2);
        launch_seq();
        for (int k = 0; k < 3; k++) pulse(0);
        chk("R8 stalled at lock phase", int'(phase), 2);
        chk("R8 lock_ok low", int'(lock_ok), 0);
        lock_in = 1'b1;
        pulse(0);
        chk("R8 advance after lock", int'(phase), 3);
        chk("R8 lock_ok high", int'(lock_ok), 1);

        // R10: settings frozen, repeated start ignored
        do_reset();
        set_codes(2'd0, 1'b0, 3'd1, 3'd3, 3'd1, 3'd1, 3'd7);
        launch_seq();
        set_codes(2'd1, 1'b0, 3'd1, 3'd1, 3'd1, 3'd1, 3'd7);
        pulse(0);
        chk("R10 out_en keeps captured code", int'(out_en), 0);
        pulse(0);
        chk("R10 select keeps captured source", int'(phase), 2);
        for (int k = 0; k < 5; k++) pulse(0);
        chk("R10 reached last phase", int'(phase), 7);
        @(negedge clk) cfg_complete = 1'b0;
        @(negedge clk) cfg_complete = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 second start ignored", int'(phase), 7);
        chk("R9 events sticky", int'({done_drive, out_en, gsr_rel, gwe_rel, lock_ok}), 31);

        // R9: reset clears everything
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        chk("R9 reset clears phase", int'(phase), 0);
        chk("R9 reset clears events", int'({done_drive, out_en, gsr_rel, gwe_rel, lock_ok, finished}), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule